// File: doc/BRIEF.md
# Passive Cell Balancing Controller

This block makes the balancing decisions for a series pack of four lithium iron phosphate cells that are balanced by resistive bypass. Each time a sample strobe arrives it reads the digitized cell voltages, a signed pack current and one temperature per cell. From these it sets the charge or discharge mode, the bypass enable for each cell, and the flags for over-temperature, under-voltage and a full pack. The outputs are registered. They change only at the strobe edge and hold their values until the next strobe.

A small register port sits on the host side, behind whatever serial engine the chip uses. Through it the host reads and writes the full and empty voltage thresholds, the balancing step and the temperature limit. The host can also force one cell into bypass for a set number of sample periods, whatever the automatic rule would decide. The block has no analog front end, no charge estimation and no bus protocol logic.

Top module: `cell_balance_ctrl`

## Requirements
- R1: At each strobe, a pack current above +DBAND (default 20, positive means the charge direction) selects charging. A current below -DBAND selects discharging. A current from -DBAND to +DBAND inclusive keeps the previous mode. After reset the mode is discharging.
- R2: While charging, a cell's bypass turns on when its voltage is greater than or equal to the lowest cell voltage plus the step register.
- R3: While charging, a cell at or above the full threshold is bypassed even if the step rule would leave it off.
- R4: While discharging, no cell is bypassed unless a manual override is running for it.
- R5: If any cell temperature is strictly above the temperature limit at a strobe, then all bypasses turn off, overtemp_o is set and every running manual override is cancelled. The next strobe with no hot cell clears overtemp_o.
- R6: Writing N to address 4+i gives cell i bypass for the next N strobes, in either mode. Writing 0 cancels the override. Writes to these addresses are ignored while overtemp_o is high.
- R7: undervolt_o is set at a strobe when the new mode is discharging and at least one cell is at or below the empty threshold. Otherwise it is cleared.
- R8: done_o is set at a strobe when the new mode is charging and every cell is at or above the full threshold. Otherwise it is cleared.
- R9: The registers sit at these addresses: 0 is the full threshold (reset 3600), 1 is the empty threshold (reset 2500), 2 is the step (reset 50) and 3 is the temperature limit (reset 600). Addresses 4 to 7 read back the strobes still remaining in each cell's manual override. Any other address reads as 0.
- R10: Bypass, mode, over-temperature, under-voltage and done outputs change only on the clock edge at which sample_i is high.
- R11: led_act_o is high when any bypass is on. led_chg_o follows the charging mode and led_dis_o is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_i | input | 1 | Sample strobe: re-evaluate all decisions |
| cell_mv_i | input | 64 | Cell voltages in mV, cell i at bits [16i+15:16i] |
| pack_ma_i | input | 16 | Signed pack current, positive when charging |
| cell_temp_i | input | 64 | Cell temperature codes, cell i at bits [16i+15:16i] |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| bypass_o | output | 4 | Per-cell bypass enables |
| charging_o | output | 1 | 1 while in charging mode |
| overtemp_o | output | 1 | Over-temperature status |
| undervolt_o | output | 1 | Under-voltage status |
| done_o | output | 1 | Pack full |
| led_act_o | output | 1 | Balancing activity indicator |
| led_chg_o | output | 1 | Charge indicator |
| led_dis_o | output | 1 | Discharge indicator |

## Verification
Every decision output is latched at the edge where sample_i is high. The bench holds the strobe for exactly one cycle and compares all outputs at the following falling edge, which is the first point at which the new values can be seen. Register writes take effect at the edge where the write is sampled. The read data is combinational, so readbacks are compared half a cycle after the address is driven. For R10, the bench changes every input after a strobe and runs several cycles with no strobe. It then checks that the outputs still hold the values from the last strobe.

// File: rtl/cell_balance_ctrl.sv
module cell_balance_ctrl #(
  parameter int NCELL    = 4,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int AW       = 3,
  parameter int DBAND    = 20,
  parameter int VMAX_RST = 3600,
  parameter int VMIN_RST = 2500,
  parameter int STEP_RST = 50,
  parameter int TLIM_RST = 600
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_i,
  input  logic [NCELL*DW-1:0]    cell_mv_i,
  input  logic signed [CW-1:0]   pack_ma_i,
  input  logic [NCELL*DW-1:0]    cell_temp_i,
  input  logic                   reg_we_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic [DW-1:0]          reg_wdata_i,
  output logic [DW-1:0]          reg_rdata_o,
  output logic [NCELL-1:0]       bypass_o,
  output logic                   charging_o,
  output logic                   overtemp_o,
  output logic                   undervolt_o,
  output logic                   done_o,
  output logic                   led_act_o,
  output logic                   led_chg_o,
  output logic                   led_dis_o
);
  localparam int MAN_BASE = 4;
  localparam logic signed [CW-1:0] DB_POS = CW'(DBAND);
  localparam logic signed [CW-1:0] DB_NEG = -DB_POS;

  logic [DW-1:0] vmax_q, vmin_q, step_q, tlim_q;
  logic [DW-1:0] man_q [NCELL];
  logic [DW-1:0] cv [NCELL];
  logic [DW-1:0] ct [NCELL];
  logic [NCELL-1:0] byp_q, hot, low, full, high, autob, man_on;
  logic chg_q, ot_q, uv_q, done_q;
  logic [DW-1:0] vlow;
  logic [DW:0] thr;
  logic chg_nx, ot_nx;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign cv[i]     = cell_mv_i[i*DW +: DW];
    assign ct[i]     = cell_temp_i[i*DW +: DW];
    assign hot[i]    = ct[i] > tlim_q;
    assign low[i]    = cv[i] <= vmin_q;
    assign full[i]   = cv[i] >= vmax_q;
    assign high[i]   = {1'b0, cv[i]} >= thr;
    assign autob[i]  = chg_nx && (high[i] || full[i]);
    assign man_on[i] = man_q[i] != '0;

    wire wr_hit = reg_we_i && (reg_addr_i == AW'(MAN_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   man_q[i] <= '0;
      else if (sample_i && ot_nx)   man_q[i] <= '0;
      else if (wr_hit && !ot_q)     man_q[i] <= reg_wdata_i;
      else if (sample_i && man_on[i]) man_q[i] <= man_q[i] - 1'b1;
    end
  end

  always_comb begin
    vlow = cv[0];
    for (int i = 1; i < NCELL; i++)
      if (cv[i] < vlow) vlow = cv[i];
  end

  assign thr    = {1'b0, vlow} + {1'b0, step_q};
  assign chg_nx = (pack_ma_i > DB_POS) ? 1'b1 : (pack_ma_i < DB_NEG) ? 1'b0 : chg_q;
  assign ot_nx  = |hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q  <= 1'b0;
      ot_q   <= 1'b0;
      uv_q   <= 1'b0;
      done_q <= 1'b0;
      byp_q  <= '0;
    end else if (sample_i) begin
      chg_q  <= chg_nx;
      ot_q   <= ot_nx;
      uv_q   <= !chg_nx && (|low);
      done_q <= chg_nx && (&full);
      byp_q  <= ot_nx ? '0 : (man_on | autob);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmax_q <= DW'(VMAX_RST);
      vmin_q <= DW'(VMIN_RST);
      step_q <= DW'(STEP_RST);
      tlim_q <= DW'(TLIM_RST);
    end else if (reg_we_i) begin
      case (reg_addr_i)
        AW'(0): vmax_q <= reg_wdata_i;
        AW'(1): vmin_q <= reg_wdata_i;
        AW'(2): step_q <= reg_wdata_i;
        AW'(3): tlim_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      AW'(0):  reg_rdata_o = vmax_q;
      AW'(1):  reg_rdata_o = vmin_q;
      AW'(2):  reg_rdata_o = step_q;
      AW'(3):  reg_rdata_o = tlim_q;
      default: reg_rdata_o = '0;
    endcase
    for (int i = 0; i < NCELL; i++)
      if (reg_addr_i == AW'(MAN_BASE + i)) reg_rdata_o = man_q[i];
  end

  assign bypass_o    = byp_q;
  assign charging_o  = chg_q;
  assign overtemp_o  = ot_q;
  assign undervolt_o = uv_q;
  assign done_o      = done_q;
  assign led_act_o   = |byp_q;
  assign led_chg_o   = chg_q;
  assign led_dis_o   = !chg_q;

  AST_DEADBAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i && pack_ma_i >= DB_NEG && pack_ma_i <= DB_POS |=> $stable(charging_o)); // R1
  AST_DISCH_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i && pack_ma_i < DB_NEG && man_on == '0 |=> bypass_o == '0); // R4
  AST_HOT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp_o |-> bypass_o == '0); // R5
  AST_HOT_CANCELS_MAN: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp_o |-> man_on == '0); // R6
  AST_UV_IN_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    undervolt_o |-> !charging_o); // R7
  AST_DONE_IN_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> charging_o); // R8
  AST_HELD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(bypass_o) && $stable(charging_o) && $stable(done_o)
                  && $stable(overtemp_o) && $stable(undervolt_o)); // R10
endmodule

// File: tb/tb_cell_balance_ctrl.sv
`timescale 1ns/1ps
module tb_cell_balance_ctrl;
  localparam int N = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sample, we;
  logic [2:0] addr;
  logic [15:0] wdata, rdata;
  logic signed [15:0] pack;
  logic [N*16-1:0] vbus, tbus;
  logic [15:0] v_in [N];
  logic [15:0] t_in [N];
  logic [N-1:0] byp;
  logic chg, ot, uv, done, la, lc, ld;

  always_comb
    for (int i = 0; i < N; i++) begin
      vbus[i*16 +: 16] = v_in[i];
      tbus[i*16 +: 16] = t_in[i];
    end

  cell_balance_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .cell_mv_i(vbus), .pack_ma_i(pack),
    .cell_temp_i(tbus), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .bypass_o(byp), .charging_o(chg), .overtemp_o(ot),
    .undervolt_o(uv), .done_o(done), .led_act_o(la), .led_chg_o(lc), .led_dis_o(ld));

  int tests = 0, fails = 0;
  bit finished = 0;
  int m_vmax = 3600, m_vmin = 2500, m_step = 50, m_tlim = 600;
  bit m_chg = 0, m_ot = 0, e_uv = 0, e_done = 0;
  int m_cnt [N] = '{0, 0, 0, 0};
  logic [N-1:0] e_byp = '0;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    we = 0;
    case (a)
      0: m_vmax = d;
      1: m_vmin = d;
      2: m_step = d;
      3: m_tlim = d;
      default: if (a >= 4 && a < 4 + N && !m_ot) m_cnt[a-4] = d;
    endcase
  endtask

  task automatic rd_check(string req, int a, int exp);
    @(negedge clk);
    addr = 3'(a);
    #1;
    check(req, int'(rdata), exp);
  endtask

  function automatic int lowest();
    int mn = v_in[0];
    for (int i = 1; i < N; i++) if (v_in[i] < mn) mn = v_in[i];
    return mn;
  endfunction

  task automatic model_step(int cur);
    int mn = lowest();
    bit anyhot = 0, anylow = 0, allfull = 1;
    if (cur > 20) m_chg = 1;
    else if (cur < -20) m_chg = 0;
    for (int i = 0; i < N; i++) begin
      if (t_in[i] > m_tlim) anyhot = 1;
      if (v_in[i] <= m_vmin) anylow = 1;
      if (v_in[i] < m_vmax) allfull = 0;
    end
    e_uv = !m_chg && anylow;
    e_done = m_chg && allfull;
    for (int i = 0; i < N; i++) begin
      bit on = m_cnt[i] != 0;
      bit a = m_chg && ((v_in[i] >= mn + m_step) || (v_in[i] >= m_vmax));
      e_byp[i] = !anyhot && (on || a);
      m_cnt[i] = anyhot ? 0 : (on ? m_cnt[i] - 1 : m_cnt[i]);
    end
    m_ot = anyhot;
  endtask

  task automatic strobe(int cur);
    @(negedge clk);
    pack = 16'(cur);
    sample = 1;
    @(negedge clk);
    sample = 0;
    model_step(cur);
  endtask

  task automatic check_all(string breq);
    check(breq, int'(byp), int'(e_byp));
    check("R1 mode", int'(chg), int'(m_chg));
    check("R5 overtemp", int'(ot), int'(m_ot));
    check("R7 undervolt", int'(uv), int'(e_uv));
    check("R8 done", int'(done), int'(e_done));
    check("R11 leds", int'({la, lc, ld}), int'({|e_byp, m_chg, !m_chg}));
  endtask

  task automatic setv(int a, int b, int c, int d);
    v_in[0] = 16'(a); v_in[1] = 16'(b); v_in[2] = 16'(c); v_in[3] = 16'(d);
  endtask

  task automatic sett(int a);
    for (int i = 0; i < N; i++) t_in[i] = 16'(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; sample = 0; we = 0; addr = '0; wdata = '0; pack = '0;
    setv(3300, 3300, 3300, 3300); sett(250);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset bypass", int'(byp), 0);
    check("R1 reset mode", int'(chg), 0);
    check("R11 reset leds", int'({la, lc, ld}), 1);
    check("R5 reset ot", int'(ot), 0);
    rd_check("R9 vmax", 0, 3600);
    rd_check("R9 vmin", 1, 2500);
    rd_check("R9 step", 2, 50);
    rd_check("R9 tlim", 3, 600);

    setv(3300, 3349, 3350, 3400);
    strobe(1000);      check_all("R2 step boundary");
    strobe(10);        check_all("R1 deadband hold charge");
    check("R2 byp pattern", int'(byp), 4'b1100);

    wr(2, 500); rd_check("R9 step write", 2, 500);
    setv(3300, 3300, 3600, 3400);
    strobe(800);       check_all("R3 full cell");
    check("R3 byp pattern", int'(byp), 4'b0100);

    setv(3600, 3650, 3600, 3700);
    strobe(800);       check_all("R8 all full");
    check("R8 done", int'(done), 1);

    setv(2500, 3500, 3300, 3300);
    strobe(-1000);     check_all("R4 discharge no bypass");
    check("R7 uv edge", int'(uv), 1);
    strobe(-15);       check_all("R1 deadband hold discharge");

    wr(2, 50);
    setv(3300, 3300, 3300, 3300);
    wr(5, 3);
    rd_check("R9 man readback", 5, 3);
    strobe(-1000);     check_all("R6 manual 1");
    rd_check("R9 man remaining", 5, 2);
    strobe(-1000);     check_all("R6 manual 2");
    strobe(-1000);     check_all("R6 manual 3");
    strobe(-1000);     check_all("R6 manual expired");
    check("R6 off after N", int'(byp), 0);

    wr(4, 10);
    sett(601);
    strobe(-1000);     check_all("R5 hot");
    rd_check("R5 man cancelled", 4, 0);
    wr(6, 7);
    rd_check("R6 write ignored hot", 6, 0);
    sett(600);
    strobe(-1000);     check_all("R5 cleared at limit");

    setv(3300, 3400, 3300, 3300);
    strobe(900);
    check("R10 pre", int'(byp), 4'b0010);
    setv(3700, 3300, 3300, 3300); sett(900); pack = -16'sd900;
    repeat (5) @(negedge clk);
    check_all("R10 held without strobe");
    sett(250);

    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < N; i++) begin
        v_in[i] = 16'(3200 + $urandom % 450);
        if ($urandom % 10 == 0) v_in[i] = 16'(2400 + $urandom % 200);
        t_in[i] = 16'(200 + $urandom % 430);
      end
      if ($urandom % 6 == 0) wr(4 + int'($urandom % N), int'($urandom % 6));
      if ($urandom % 4 == 0) strobe(int'($urandom % 61) - 30);
      else strobe(int'($urandom % 2001) - 1000);
      check_all("R2 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule